// File: doc/BRIEF.md
# Packet-Aware Receive Byte FIFO

This block buffers received bytes between a bit-level frame deframer and a host register interface. Each byte from the deframer is stored together with an end-of-frame marker and a two-bit frame status. The host pops bytes one at a time from the head. It also reads an availability word that tells it how many bytes it may take without crossing into the next frame.

The availability word never reaches past the first end-of-frame marker ahead of the read position. Its top bit is set when the counted bytes do not yet close a frame, which happens for the opening part of a frame or a middle part of one. When that bit is clear and the count is non-zero, the last counted byte ends a frame, and the host should then inspect the status returned with that byte. A real-time flag compares the fill level against a watermark that the host can write.

A write into a full FIFO with no pop in the same cycle is an overrun. On an overrun the buffer is emptied, the frame in progress is lost, and a one-cycle event is raised. The block then ignores every byte until the deframer marks the first byte of a new frame.

Top module: `hrx_pkt_fifo`

## Requirements
- R1: After synchronous reset the FIFO is empty: `avail` is 0, `rd_data`/`rd_eop`/`rd_stat` are 0, `high_wm` and `ovr_evt` are 0, and the watermark equals `WM_INIT`.
- R2: Bytes leave in the order they were written. Each byte keeps its end-of-frame bit and its status code (00 good, 01 aborted, 10 check error, 11 overrun). `rd_data`, `rd_eop` and `rd_stat` show the head entry combinationally, and `rd_pop` removes it at the clock edge.
- R3: `avail[6:0]` equals the number of stored bytes from the head up to and including the first byte marked end-of-frame. If no stored byte is marked, it equals the total fill.
- R4: `avail[7]` is 1 exactly when the FIFO is non-empty and no stored byte carries an end-of-frame mark. Otherwise it is 0.
- R5: A pop while the FIFO is empty has no effect, and the read outputs are 0 while empty.
- R6: A write and a pop in the same cycle on a full FIFO are both performed, with no overrun.
- R7: `high_wm` is 1 whenever the fill level is strictly greater than the watermark register. A watermark of 0 therefore flags any non-empty FIFO. A write through `wm_wr` takes effect from the next cycle.
- R8: A write that arrives while the FIFO holds 64 bytes, with no pop in the same cycle, empties the FIFO. `ovr_evt` is 1 for exactly the next cycle, and the written byte is lost.
- R9: After an overrun, writes are discarded until one arrives with `wr_sop` = 1. That byte is stored, and normal operation resumes.
- R10: The FIFO holds 64 bytes. With 64 unmarked bytes stored, `avail` reads 8'hC0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_valid | input | 1 | Byte offered by the deframer |
| wr_sop | input | 1 | Byte is the first of a frame |
| wr_data | input | 8 | Received byte |
| wr_eop | input | 1 | Byte is the last of a frame |
| wr_stat | input | 2 | Frame status that travels with the byte |
| rd_pop | input | 1 | Host removes the head byte |
| rd_data | output | 8 | Head byte, 0 when empty |
| rd_eop | output | 1 | End-of-frame mark of the head byte |
| rd_stat | output | 2 | Status of the head byte |
| avail | output | 8 | Bit 7: frame continues; bits 6:0: readable bytes |
| wm_wr | input | 1 | Load the watermark register |
| wm_value | input | 7 | New watermark value |
| high_wm | output | 1 | Fill level above the watermark |
| ovr_evt | output | 1 | One-cycle overrun event |

## Verification
The assertions check relations that must hold on every cycle. The count never exceeds the fill level, and neither exceeds the depth. A set continue bit means the whole fill is counted. An empty FIFO shows zero data and no watermark flag. An overrun event always coincides with an empty FIFO, and the FIFO never grows while bytes are being discarded. Only the bench's scenarios can show that bytes and status come out in order and that the count stops exactly at the right marker. The same holds for the watermark threshold, the simultaneous push and pop at full, and the recovery on the next frame start, all checked against a queue model.

// File: rtl/hrx_pkg.sv
package hrx_pkg;

    localparam int BYTE_W = 8;

    typedef enum logic [1:0] {
        ST_GOOD  = 2'b00,
        ST_ABORT = 2'b01,
        ST_CHECK = 2'b10,
        ST_OVR   = 2'b11
    } frm_stat_e;

    typedef struct packed {
        logic [BYTE_W-1:0] data;
        logic              eop;
        frm_stat_e         stat;
    } slot_t;

    localparam slot_t SLOT_ZERO = '{data: '0, eop: 1'b0, stat: ST_GOOD};

endpackage

// File: rtl/hrx_store.sv
module hrx_store
    import hrx_pkg::*;
#(
    parameter int DEPTH = 64,
    parameter int AW    = $clog2(DEPTH),
    parameter int CW    = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             push,
    input  logic             pop,
    input  logic             flush,
    input  slot_t            wr_slot,
    output slot_t            head,
    output logic [CW-1:0]    fill,
    output logic [AW-1:0]    rd_ptr,
    output logic [DEPTH-1:0] eop_map
);

    slot_t             mem [DEPTH];
    logic [AW-1:0]     wr_ptr;
    logic [DEPTH-1:0]  eop_q;

    always_ff @(posedge clk) begin
        if (push) begin
            mem[wr_ptr] <= wr_slot;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            fill   <= '0;
            eop_q  <= '0;
        end else begin
            if (push) begin
                wr_ptr        <= wr_ptr + 1'b1;
                eop_q[wr_ptr] <= wr_slot.eop;
            end
            if (pop) begin
                rd_ptr <= rd_ptr + 1'b1;
            end
            case ({push, pop})
                2'b10:   fill <= fill + 1'b1;
                2'b01:   fill <= fill - 1'b1;
                default: fill <= fill;
            endcase
        end
    end

    assign head    = (fill == '0) ? SLOT_ZERO : mem[rd_ptr];
    assign eop_map = eop_q;

endmodule

// File: rtl/hrx_chunk_scan.sv
module hrx_chunk_scan #(
    parameter int DEPTH = 64,
    parameter int AW    = $clog2(DEPTH),
    parameter int CW    = $clog2(DEPTH + 1)
) (
    input  logic [AW-1:0]    rd_ptr,
    input  logic [CW-1:0]    fill,
    input  logic [DEPTH-1:0] eop_map,
    output logic [CW-1:0]    chunk_len,
    output logic             more
);

    logic [DEPTH-1:0] hit;

    // rotate the end-of-frame map so that position 0 is the head
    for (genvar g = 0; g < DEPTH; g++) begin : g_rot
        logic [AW-1:0] idx;
        assign idx    = rd_ptr + AW'(g);
        assign hit[g] = eop_map[idx] && (CW'(g) < fill);
    end

    always_comb begin
        logic found;
        found     = 1'b0;
        chunk_len = fill;
        for (int i = 0; i < DEPTH; i++) begin
            if (!found && hit[i]) begin
                found     = 1'b1;
                chunk_len = CW'(i + 1);
            end
        end
        more = (fill != '0) && !found;
    end

endmodule

// File: rtl/hrx_wm_flag.sv
module hrx_wm_flag #(
    parameter int CW      = 7,
    parameter int WM_INIT = 48
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wm_wr,
    input  logic [CW-1:0] wm_value,
    input  logic [CW-1:0] fill,
    output logic          high
);

    logic [CW-1:0] wm_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            wm_q <= CW'(WM_INIT);
        end else if (wm_wr) begin
            wm_q <= wm_value;
        end
    end

    assign high = fill > wm_q;

endmodule

// File: rtl/hrx_pkt_fifo.sv
module hrx_pkt_fifo
    import hrx_pkg::*;
#(
    parameter int DEPTH   = 64,
    parameter int WM_INIT = 48,
    localparam int AW     = $clog2(DEPTH),
    localparam int CW     = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_valid,
    input  logic          wr_sop,
    input  logic [7:0]    wr_data,
    input  logic          wr_eop,
    input  logic [1:0]    wr_stat,
    input  logic          rd_pop,
    output logic [7:0]    rd_data,
    output logic          rd_eop,
    output logic [1:0]    rd_stat,
    output logic [CW:0]   avail,
    input  logic          wm_wr,
    input  logic [CW-1:0] wm_value,
    output logic          high_wm,
    output logic          ovr_evt
);

    slot_t            head;
    slot_t            wr_slot;
    logic [CW-1:0]    fill;
    logic [AW-1:0]    rd_ptr;
    logic [DEPTH-1:0] eop_map;
    logic [CW-1:0]    chunk_len;
    logic             more;
    logic             drop_q;
    logic             full;
    logic             pop_ok;
    logic             accept;
    logic             overrun;
    logic             push;

    assign full    = (fill == CW'(DEPTH));
    assign pop_ok  = rd_pop && (fill != '0);
    assign accept  = wr_valid && (!drop_q || wr_sop);
    assign overrun = accept && full && !pop_ok;
    assign push    = accept && !overrun;

    assign wr_slot = '{data: wr_data, eop: wr_eop, stat: frm_stat_e'(wr_stat)};

    always_ff @(posedge clk) begin
        if (rst) begin
            drop_q  <= 1'b0;
            ovr_evt <= 1'b0;
        end else begin
            ovr_evt <= overrun;
            if (overrun) begin
                drop_q <= 1'b1;
            end else if (accept) begin
                drop_q <= 1'b0;
            end
        end
    end

    hrx_store #(.DEPTH(DEPTH), .AW(AW), .CW(CW)) u_store (
        .clk     (clk),
        .rst     (rst),
        .push    (push),
        .pop     (pop_ok),
        .flush   (overrun),
        .wr_slot (wr_slot),
        .head    (head),
        .fill    (fill),
        .rd_ptr  (rd_ptr),
        .eop_map (eop_map)
    );

    hrx_chunk_scan #(.DEPTH(DEPTH), .AW(AW), .CW(CW)) u_scan (
        .rd_ptr    (rd_ptr),
        .fill      (fill),
        .eop_map   (eop_map),
        .chunk_len (chunk_len),
        .more      (more)
    );

    hrx_wm_flag #(.CW(CW), .WM_INIT(WM_INIT)) u_wm (
        .clk      (clk),
        .rst      (rst),
        .wm_wr    (wm_wr),
        .wm_value (wm_value),
        .fill     (fill),
        .high     (high_wm)
    );

    assign rd_data = head.data;
    assign rd_eop  = head.eop;
    assign rd_stat = head.stat;
    assign avail   = {more, chunk_len};

endmodule

// File: rtl/hrx_pkt_fifo_chk.sv
module hrx_pkt_fifo_chk #(
    parameter int DEPTH = 64,
    parameter int CW    = 7
) (
    input logic          clk,
    input logic          rst,
    input logic [CW-1:0] fill,
    input logic [CW:0]   avail,
    input logic [7:0]    rd_data,
    input logic          high_wm,
    input logic          ovr_evt,
    input logic          drop_q,
    input logic          wr_sop
);

    // R10
    fill_bound_chk: assert property (@(posedge clk) disable iff (rst)
        fill <= CW'(DEPTH));

    // R3
    avail_le_fill_chk: assert property (@(posedge clk) disable iff (rst)
        avail[CW-1:0] <= fill);

    // R3
    avail_nonzero_chk: assert property (@(posedge clk) disable iff (rst)
        (fill != '0) |-> (avail[CW-1:0] != '0));

    // R4
    cont_whole_chk: assert property (@(posedge clk) disable iff (rst)
        avail[CW] |-> (avail[CW-1:0] == fill));

    // R5
    empty_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (fill == '0) |-> (rd_data == 8'h00 && avail == '0));

    // R7
    hwm_empty_chk: assert property (@(posedge clk) disable iff (rst)
        (fill == '0) |-> !high_wm);

    // R8
    ovr_flush_chk: assert property (@(posedge clk) disable iff (rst)
        ovr_evt |-> (fill == '0));

    // R8
    ovr_single_chk: assert property (@(posedge clk) disable iff (rst)
        ovr_evt |=> !ovr_evt);

    // R9
    drop_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (drop_q && !wr_sop) |=> (fill <= $past(fill)));

endmodule

bind hrx_pkt_fifo hrx_pkt_fifo_chk #(.DEPTH(DEPTH), .CW(CW)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .fill    (fill),
    .avail   (avail),
    .rd_data (rd_data),
    .high_wm (high_wm),
    .ovr_evt (ovr_evt),
    .drop_q  (drop_q),
    .wr_sop  (wr_sop)
);

// File: tb/test_hrx_pkt_fifo.sv
`timescale 1ns/1ps
module test_hrx_pkt_fifo;

    localparam int DEPTH = 64;
    localparam int CW    = 7;
    localparam int WMI   = 48;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic          rst = 1'b1;
    logic          wr_valid = 0, wr_sop = 0, wr_eop = 0, rd_pop = 0, wm_wr = 0;
    logic [7:0]    wr_data = 0;
    logic [1:0]    wr_stat = 0;
    logic [CW-1:0] wm_value = 0;
    logic [7:0]    rd_data;
    logic          rd_eop, high_wm, ovr_evt;
    logic [1:0]    rd_stat;
    logic [CW:0]   avail;

    hrx_pkt_fifo #(.DEPTH(DEPTH), .WM_INIT(WMI)) i_hrx_pkt_fifo (
        .clk(clk), .rst(rst), .wr_valid(wr_valid), .wr_sop(wr_sop),
        .wr_data(wr_data), .wr_eop(wr_eop), .wr_stat(wr_stat),
        .rd_pop(rd_pop), .rd_data(rd_data), .rd_eop(rd_eop),
        .rd_stat(rd_stat), .avail(avail), .wm_wr(wm_wr),
        .wm_value(wm_value), .high_wm(high_wm), .ovr_evt(ovr_evt)
    );

    typedef struct { int d; int e; int s; } ent_t;
    ent_t q[$];
    bit   m_drop = 0;
    int   m_ovr  = 0;
    int   m_wm   = WMI;
    int   checks = 0;
    int   errors = 0;
    bit   done   = 0;

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic int exp_len();
        foreach (q[i]) if (q[i].e != 0) return i + 1;
        return q.size();
    endfunction

    function automatic int exp_more();
        foreach (q[i]) if (q[i].e != 0) return 0;
        return (q.size() > 0) ? 1 : 0;
    endfunction

    task automatic compare();
        chk("R2 rd_data", rd_data, q.size() ? q[0].d : 0);
        chk("R2 rd_eop",  rd_eop,  q.size() ? q[0].e : 0);
        chk("R2 rd_stat", rd_stat, q.size() ? q[0].s : 0);
        chk("R3 avail count", avail[CW-1:0], exp_len());
        chk("R4 continue bit", avail[CW], exp_more());
        chk("R7 high_wm", high_wm, (q.size() > m_wm) ? 1 : 0);
        chk("R8 ovr_evt", ovr_evt, m_ovr);
    endtask

    task automatic model_step();
        bit pop_ok, acc, ov;
        if (rst) begin
            q.delete(); m_drop = 0; m_ovr = 0; m_wm = WMI;
            return;
        end
        pop_ok = rd_pop && q.size() > 0;
        acc    = wr_valid && (!m_drop || wr_sop);
        ov     = acc && q.size() == DEPTH && !pop_ok;
        m_ovr  = ov;
        if (ov) begin
            q.delete(); m_drop = 1;
        end else begin
            if (pop_ok) void'(q.pop_front());
            if (acc) begin
                q.push_back('{d: wr_data, e: wr_eop, s: wr_stat});
                m_drop = 0;
            end
        end
        if (wm_wr) m_wm = wm_value;
    endtask

    task automatic tick();
        @(posedge clk);
        model_step();
        @(negedge clk);
        compare();
        wr_valid = 0; wr_sop = 0; wr_eop = 0; rd_pop = 0; wm_wr = 0;
    endtask

    task automatic drive(bit v, bit sop, int d, bit e, int s, bit p);
        wr_valid = v; wr_sop = sop; wr_data = d[7:0]; wr_eop = e;
        wr_stat = s[1:0]; rd_pop = p;
        tick();
    endtask

    task automatic set_wm(int w);
        wm_wr = 1; wm_value = w[CW-1:0];
        tick();
    endtask

    initial begin
        #(4 * 100000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog (all requirements) actual=running expected=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        tick(); tick(); tick();
        rst = 0;
        tick();
        // R1 reset state
        chk("R1 avail after reset", avail, 0);
        chk("R1 rd_data after reset", rd_data, 0);
        chk("R1 high_wm after reset", high_wm, 0);
        chk("R1 ovr_evt after reset", ovr_evt, 0);

        // R2 R3 R4: one closed frame followed by an open one
        drive(1, 1, 8'h11, 0, 0, 0);
        drive(1, 0, 8'h22, 0, 0, 0);
        drive(1, 0, 8'h33, 1, 0, 0);
        drive(1, 1, 8'h44, 0, 0, 0);
        drive(1, 0, 8'h45, 0, 0, 0);
        chk("R3 count stops at frame end", avail, 3);
        chk("R2 head byte", rd_data, 8'h11);
        drive(0, 0, 0, 0, 0, 1);
        drive(0, 0, 0, 0, 0, 1);
        chk("R2 third byte with mark", rd_eop, 1);
        drive(0, 0, 0, 0, 0, 1);
        chk("R4 open frame flagged", avail, 8'h82);
        drive(1, 0, 8'h46, 1, 2, 0);
        chk("R4 closed frame not flagged", avail, 3);
        drive(0, 0, 0, 0, 0, 1);
        drive(0, 0, 0, 0, 0, 1);
        chk("R2 status of last byte", rd_stat, 2);
        drive(0, 0, 0, 0, 0, 1);

        // R5 pop on empty
        drive(0, 0, 0, 0, 0, 1);
        chk("R5 empty pop avail", avail, 0);
        chk("R5 empty pop data", rd_data, 0);

        // R7 watermark
        set_wm(0);
        drive(1, 1, 8'h5A, 1, 1, 0);
        chk("R7 zero watermark flags non-empty", high_wm, 1);
        set_wm(5);
        for (int i = 0; i < 4; i++) drive(1, 1, i, 1, 0, 0);
        chk("R7 fill 5 equals watermark", high_wm, 0);
        drive(1, 1, 8'h77, 1, 3, 0);
        chk("R7 fill 6 above watermark", high_wm, 1);
        for (int i = 0; i < 6; i++) drive(0, 0, 0, 0, 0, 1);
        set_wm(WMI);

        // R10 capacity, R6 push+pop at full, R8 overrun, R9 discard
        for (int i = 0; i < DEPTH; i++) drive(1, i == 0, i, 0, 0, 0);
        chk("R10 full open frame", avail, 8'hC0);
        drive(1, 0, 8'hE0, 0, 0, 1);
        chk("R6 no overrun on push with pop", ovr_evt, 0);
        chk("R6 still full", avail, 8'hC0);
        drive(1, 0, 8'hE1, 1, 0, 0);
        chk("R8 overrun event", ovr_evt, 1);
        chk("R8 flushed", avail, 0);
        drive(1, 0, 8'hE2, 1, 0, 0);
        drive(1, 0, 8'hE3, 0, 0, 0);
        chk("R9 bytes discarded", avail, 0);
        chk("R8 event lasts one cycle", ovr_evt, 0);
        drive(1, 1, 8'hF0, 1, 0, 0);
        chk("R9 frame start accepted", avail, 1);
        chk("R9 stored byte", rd_data, 8'hF0);
        drive(0, 0, 0, 0, 0, 1);

        // mixed traffic, every cycle compared against the model
        for (int ph = 0; ph < 6; ph++) begin
            for (int c = 0; c < 600; c++) begin
                int pr;
                pr = (ph % 2 == 0) ? 3 : 12;
                if ($urandom_range(0, 99) == 0) begin
                    set_wm($urandom_range(0, DEPTH));
                end else begin
                    drive($urandom_range(0, 9) < 8, $urandom_range(0, 7) == 0,
                          $urandom_range(0, 255), $urandom_range(0, 5) == 0,
                          $urandom_range(0, 3), $urandom_range(0, 15) < pr);
                end
            end
        end

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule